// File: doc/BRIEF.md
# UART Automatic Flow Control Unit

This block sits beside a UART's receive FIFO and its transmitter. It makes two flow-control decisions. The first is the level of the RTS line, which is driven from the fill level of the receive FIFO. The second is whether the transmitter may begin its next character, which is decided from XON and XOFF characters found in the received stream.

For hardware control, two 4-bit threshold fields set a halt level and a resume level. Each step of a field is 8 words. RTS drops when the FIFO fills to the halt level. It rises again only after the FIFO has drained to the resume level, so the gap between the two levels gives hysteresis.

For software control, every received word is compared with an XOFF character and an XON character. XOFF pauses the transmitter and XON releases it. Reception is not touched. A separate transmit-disable input also stops the transmitter. Neither the pause nor the disable cuts a character short, because the transmit-enable output only changes at a character boundary reported by the transmitter.

When hardware control is off, RTS follows a manual bit. A clock-select input hands the pin over to the baud clock instead.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset the flow-control state is clear. `tx_enable` is 1, and with `hw_flow_en`=1, `rts_clk_sel`=0 and a FIFO level below the halt level, `rts_out` is 1.
- R2: With `hw_flow_en`=1, a `rx_level` at or above 8×`halt_thr` makes `rts_out` 0 from the next cycle.
- R3: Once low under hardware control, `rts_out` stays 0 while `rx_level` is above 8×`resume_thr`. It returns to 1 in the cycle after a clock edge at which `rx_level` is at or below 8×`resume_thr` and below 8×`halt_thr`.
- R4: With `hw_flow_en`=0, `rts_out` equals `rts_manual`, and the halt state is cleared at the next edge.
- R5: With `rts_clk_sel`=1, `rts_out` equals `baud_clk` in the same cycle, whatever the other settings are.
- R6: With `sw_flow_en`=1, a strobed word equal to `xoff_char` pauses the transmitter. `tx_enable` goes to 0 at the first character-boundary edge after the edge that took the word.
- R7: With `sw_flow_en`=1, a strobed word equal to `xon_char` releases the pause. If the two characters are equal, XOFF takes precedence.
- R8: With `sw_flow_en`=0, received words have no effect, and the pause state is cleared at the next edge.
- R9: `tx_disable`=1 sampled at a character boundary makes `tx_enable` 0 on the next cycle.
- R10: `tx_enable` changes only at edges where `tx_char_boundary` is 1. It then takes the value "not paused and not disabled", where "paused" is the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | LVL_W | Current receive FIFO word count |
| halt_thr | input | THR_W | Halt level, in steps of 8 words |
| resume_thr | input | THR_W | Resume level, in steps of 8 words |
| hw_flow_en | input | 1 | Enables level-based RTS control |
| rts_manual | input | 1 | RTS level used when hardware control is off |
| rts_clk_sel | input | 1 | Routes baud_clk to rts_out |
| baud_clk | input | 1 | Baud-rate clock for the RTS pin |
| sw_flow_en | input | 1 | Enables XON/XOFF transmit gating |
| xon_char | input | CHAR_W | Character that releases the transmitter |
| xoff_char | input | CHAR_W | Character that pauses the transmitter |
| rx_word_valid | input | 1 | Strobe for one received word |
| rx_word | input | CHAR_W | Received word |
| tx_disable | input | 1 | Stops transmission after the current character |
| tx_char_boundary | input | 1 | Transmitter is between characters |
| rts_out | output | 1 | RTS pin level |
| tx_enable | output | 1 | Permission to start the next character |

## Verification
Two functions can act in the same cycle: a matching XOFF or XON word strobed in, and a character-boundary edge that updates the transmit gate. Random stimulus places the boundary strobe on about half of all cycles, and a directed case puts an XOFF word on the same edge as a boundary. The bench model is updated with the pause state as it stood before that edge, so it expects the gate to close only at the following boundary. A second overlap is an FIFO level that meets the halt and resume conditions together. The model lets halt win, and a directed case with equal thresholds checks this.

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int LVL_W      = 8,
  parameter int THR_W      = 4,
  parameter int STEP_SHIFT = 3,
  parameter int CHAR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [THR_W-1:0]  halt_thr,
  input  logic [THR_W-1:0]  resume_thr,
  input  logic              hw_flow_en,
  input  logic              rts_manual,
  input  logic              rts_clk_sel,
  input  logic              baud_clk,
  input  logic              sw_flow_en,
  input  logic [CHAR_W-1:0] xon_char,
  input  logic [CHAR_W-1:0] xoff_char,
  input  logic              rx_word_valid,
  input  logic [CHAR_W-1:0] rx_word,
  input  logic              tx_disable,
  input  logic              tx_char_boundary,
  output logic              rts_out,
  output logic              tx_enable
);
  localparam int CMP_W = (LVL_W > THR_W + STEP_SHIFT) ? LVL_W : THR_W + STEP_SHIFT;

  logic [CMP_W-1:0] level_w, halt_words, resume_words;
  logic             rts_halted, tx_paused;
  logic             is_xoff, is_xon;

  assign level_w      = CMP_W'(rx_level);
  assign halt_words   = CMP_W'(halt_thr) << STEP_SHIFT;
  assign resume_words = CMP_W'(resume_thr) << STEP_SHIFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rts_halted <= 1'b0;
    else if (!hw_flow_en)
      rts_halted <= 1'b0;
    else if (level_w >= halt_words)
      rts_halted <= 1'b1;
    else if (level_w <= resume_words)
      rts_halted <= 1'b0;
  end

  assign rts_out = rts_clk_sel ? baud_clk :
                   hw_flow_en  ? ~rts_halted : rts_manual;

  assign is_xoff = rx_word_valid && (rx_word == xoff_char);
  assign is_xon  = rx_word_valid && (rx_word == xon_char);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_paused <= 1'b0;
    else if (!sw_flow_en)
      tx_paused <= 1'b0;
    else if (is_xoff)
      tx_paused <= 1'b1;
    else if (is_xon)
      tx_paused <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_enable <= 1'b1;
    else if (tx_char_boundary)
      tx_enable <= ~tx_paused & ~tx_disable;
  end
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
  parameter int LVL_W      = 8,
  parameter int THR_W      = 4,
  parameter int STEP_SHIFT = 3,
  parameter int CHAR_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LVL_W-1:0]  rx_level,
  input logic [THR_W-1:0]  halt_thr,
  input logic [THR_W-1:0]  resume_thr,
  input logic              hw_flow_en,
  input logic              rts_clk_sel,
  input logic              baud_clk,
  input logic              sw_flow_en,
  input logic [CHAR_W-1:0] xoff_char,
  input logic              rx_word_valid,
  input logic [CHAR_W-1:0] rx_word,
  input logic              tx_disable,
  input logic              tx_char_boundary,
  input logic              rts_out,
  input logic              tx_enable
);
  logic [15:0] lvl, hlim, rlim;
  assign lvl  = 16'(rx_level);
  assign hlim = 16'(halt_thr) << STEP_SHIFT;
  assign rlim = 16'(resume_thr) << STEP_SHIFT;

  AST_RTS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_flow_en && lvl >= hlim) |=> (!rts_out || !hw_flow_en || rts_clk_sel)); // R2

  AST_RTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_flow_en && !rts_clk_sel && !rts_out && lvl > rlim) |=> (!rts_out || !hw_flow_en || rts_clk_sel)); // R3

  AST_XOFF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_flow_en && rx_word_valid && rx_word == xoff_char) ##1 (sw_flow_en && tx_char_boundary) |=> !tx_enable); // R6

  AST_TX_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_disable && tx_char_boundary) |=> !tx_enable); // R9

  AST_GATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_char_boundary |=> $stable(tx_enable)); // R10

  always_comb
    if (rst_n && rts_clk_sel)
      AST_RTS_CLOCK: assert (rts_out == baud_clk); // R5
endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(
  .LVL_W(LVL_W), .THR_W(THR_W), .STEP_SHIFT(STEP_SHIFT), .CHAR_W(CHAR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .halt_thr(halt_thr),
  .resume_thr(resume_thr), .hw_flow_en(hw_flow_en), .rts_clk_sel(rts_clk_sel),
  .baud_clk(baud_clk), .sw_flow_en(sw_flow_en), .xoff_char(xoff_char),
  .rx_word_valid(rx_word_valid), .rx_word(rx_word), .tx_disable(tx_disable),
  .tx_char_boundary(tx_char_boundary), .rts_out(rts_out), .tx_enable(tx_enable)
);

// File: tb/sim_uart_flow_ctl.sv
module sim_uart_flow_ctl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_level = '0;
  logic [3:0] halt_thr = 4'd8, resume_thr = 4'd2;
  logic       hw_flow_en = 1'b1, rts_manual = 1'b0, rts_clk_sel = 1'b0, baud_clk = 1'b0;
  logic       sw_flow_en = 1'b1;
  logic [7:0] xon_char = 8'h11, xoff_char = 8'h13, rx_word = '0;
  logic       rx_word_valid = 1'b0, tx_disable = 1'b0, tx_char_boundary = 1'b0;
  logic       rts_out, tx_enable;

  int total = 0, bad = 0;
  bit m_halt = 0, m_pause = 0, m_txen = 1;

  always #10 clk = ~clk;

  uart_flow_ctl u0 (.*);

  function automatic bit exp_rts();
    if (rts_clk_sel) return baud_clk;
    if (hw_flow_en)  return !m_halt;
    return rts_manual;
  endfunction

  task automatic model_step();
    bit old_pause = m_pause;
    if (!hw_flow_en) m_halt = 0;
    else if (int'(rx_level) >= 8*int'(halt_thr)) m_halt = 1;
    else if (int'(rx_level) <= 8*int'(resume_thr)) m_halt = 0;
    if (!sw_flow_en) m_pause = 0;
    else if (rx_word_valid && rx_word == xoff_char) m_pause = 1;
    else if (rx_word_valid && rx_word == xon_char) m_pause = 0;
    if (tx_char_boundary) m_txen = !old_pause && !tx_disable;
  endtask

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string rq, tq;
    if (rts_clk_sel) rq = "R5";
    else if (!hw_flow_en) rq = "R4";
    else if (m_halt) rq = "R3";
    else rq = "R2";
    check(rq, rts_out, exp_rts());
    if (!sw_flow_en) tq = "R8";
    else if (tx_disable) tq = "R9";
    else if (m_pause) tq = "R6";
    else tq = "R7";
    check(tq, tx_enable, m_txen);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    process::self().srandom(32'd7);
    repeat (3) @(negedge clk);
    check("R1", tx_enable, 1'b1);
    check("R1", rts_out, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R3 hysteresis walk
    rx_level = 8'd63; tick(); check("R2", rts_out, 1'b1);
    rx_level = 8'd64; tick(); tick(); check("R2", rts_out, 1'b0);
    rx_level = 8'd17; tick(); check("R3", rts_out, 1'b0);
    rx_level = 8'd16; tick(); tick(); check("R3", rts_out, 1'b1);
    // equal thresholds: halt wins
    halt_thr = 4'd3; resume_thr = 4'd3; rx_level = 8'd24; tick(); tick();
    check("R3", rts_out, 1'b0);
    halt_thr = 4'd8; resume_thr = 4'd2; rx_level = 8'd0; tick(); tick();

    // R6: XOFF on the same edge as a boundary
    rx_word = 8'h13; rx_word_valid = 1'b1; tx_char_boundary = 1'b1; tick();
    rx_word_valid = 1'b0;
    check("R6", tx_enable, 1'b1);
    tick();
    check("R6", tx_enable, 1'b0);
    // R10: XON without boundary leaves gate closed
    tx_char_boundary = 1'b0; rx_word = 8'h11; rx_word_valid = 1'b1; tick();
    rx_word_valid = 1'b0; tick(); tick();
    check("R10", tx_enable, 1'b0);
    tx_char_boundary = 1'b1; tick();
    check("R7", tx_enable, 1'b1);
    // R7: XON equal to XOFF -> pause
    xon_char = 8'h13; rx_word = 8'h13; rx_word_valid = 1'b1; tick();
    rx_word_valid = 1'b0; tick();
    check("R7", tx_enable, 1'b0);
    xon_char = 8'h11;
    // R8: words ignored while software control off
    sw_flow_en = 1'b0; tick(); tick();
    check("R8", tx_enable, 1'b1);
    rx_word = 8'h13; rx_word_valid = 1'b1; tick(); rx_word_valid = 1'b0; tick();
    check("R8", tx_enable, 1'b1);
    sw_flow_en = 1'b1;
    // R9
    tx_disable = 1'b1; tick(); check("R9", tx_enable, 1'b0);
    tx_disable = 1'b0; tick(); check("R9", tx_enable, 1'b1);
    // R4, R5
    hw_flow_en = 1'b0; rts_manual = 1'b0; tick(); check("R4", rts_out, 1'b0);
    rts_clk_sel = 1'b1; baud_clk = 1'b1; #1; check("R5", rts_out, 1'b1);
    baud_clk = 1'b0; #1; check("R5", rts_out, 1'b0);
    rts_clk_sel = 1'b0; hw_flow_en = 1'b1;
    tick();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 9));
      if (r < 6) begin
        int nl = int'(rx_level) + int'($urandom_range(0, 16)) - 8;
        rx_level = 8'(nl < 0 ? 0 : (nl > 128 ? 128 : nl));
      end
      if ($urandom_range(0, 99) == 0) halt_thr = 4'($urandom_range(1, 15));
      if ($urandom_range(0, 99) == 0) resume_thr = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 199) == 0) hw_flow_en = ~hw_flow_en;
      if ($urandom_range(0, 199) == 0) sw_flow_en = ~sw_flow_en;
      if ($urandom_range(0, 149) == 0) rts_clk_sel = ~rts_clk_sel;
      rts_manual = 1'($urandom);
      baud_clk = 1'($urandom);
      tx_disable = ($urandom_range(0, 19) == 0);
      tx_char_boundary = 1'($urandom);
      rx_word_valid = ($urandom_range(0, 3) == 0);
      case ($urandom_range(0, 2))
        0: rx_word = xoff_char;
        1: rx_word = xon_char;
        default: rx_word = 8'($urandom);
      endcase
      #1;
      check(rts_clk_sel ? "R5" : "R4", rts_out, exp_rts());
      tick();
    end
    finish_run();
  end
endmodule